// File: doc/BRIEF.md
# Timed Wakeup Queue

This block keeps a set of pending timed wakeups. Each one names a process, a priority and the clock value after which the process must be woken. The requests are held in a singly linked list in ascending order of wake time. The earliest request is not stored in the list. It sits in a set of dedicated head registers, and only that one time is compared against a free-running cycle counter.

When the counter passes the head time, the block presents one wakeup (process, priority) to the scheduler for one cycle. The head registers are then refilled from the first list node, and that node's slot goes back onto the free chain.

A producer inserts requests through a valid/ready port. A request that is earlier than the current head takes over the head registers, and the old head moves to the front of the list. Any other request is placed by walking the list, one node per cycle. Requests with the same time leave in the order they were accepted. When no storage is left, the block raises a full flag and withholds ready. Choosing what runs on the processors is the scheduler's job and lies outside this block.

Top module: `timed_wake_list`

## Requirements
- R1: After reset the queue is empty. `wake_valid` is 0, `full` is 0 and `ins_ready` is 1. The `now` counter starts at 0 and then advances by exactly 1 every cycle.
- R2: With the block idle, a request with time T is woken on the cycle in which `now` first reads T+2. The block registers `now` > T at one clock edge and presents the wakeup after the next edge.
- R3: A request is never presented while its time has not yet been passed by the counter. No wakeup appears before `now` reaches T+2.
- R4: Wakeups leave in ascending order of requested time, whatever the order of insertion.
- R5: Requests with equal times leave in the order in which they were accepted.
- R6: A request earlier than the current head is woken before that head, even when it is inserted later.
- R7: At most one wakeup is presented per cycle. Expired requests drain on consecutive cycles, so each one appears at max(T+2, previous wakeup cycle + 1).
- R8: The block holds DEPTH+1 requests: DEPTH list slots plus the head registers. With all of them occupied, `full` is 1 and `ins_ready` is 0, and a request held on the input is not accepted.
- R9: Slots of retired requests are reused. Once the queue has drained, `full` is 0 and the block accepts DEPTH+1 new requests again.
- R10: Each wakeup carries the process number and priority given with its request, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request present |
| ins_ready | output | 1 | Insert accepted on this clock edge |
| ins_pid | input | PID_W | Process number to wake |
| ins_pri | input | PRI_W | Priority to wake it with |
| ins_time | input | TIME_W | Counter value after which to wake |
| full | output | 1 | All storage in use |
| wake_valid | output | 1 | Wakeup presented this cycle |
| wake_pid | output | PID_W | Process number being woken |
| wake_pri | output | PRI_W | Priority supplied with the wakeup |
| now | output | TIME_W | Free-running cycle counter |

## Verification
The bench builds the block with DEPTH=4, PID_W=8, PRI_W=4 and TIME_W=16. The small depth lets five inserts fill the queue, so the full flag and the refused insert are reached quickly. A second fill after draining shows that retired slots come back through the free chain. The 16-bit time leaves ample headroom, so the counter never wraps during the run, and every expected wakeup cycle can be written as max(T+2, previous+1). The two vector groups take the list through each path: head-empty loads, displacement of the head by an earlier request, walks that stop in the middle of the list, walks that reach the tail, and runs of equal times.

// File: rtl/wtl_pkg.sv
package wtl_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WALK = 2'd1,
        S_LINK = 2'd2
    } wtl_state_e;

endpackage

// File: rtl/wtl_rtc.sv
module wtl_rtc #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + TIME_W'(1);
    end

endmodule

// File: rtl/wtl_node_ram.sv
module wtl_node_ram #(
    parameter int DEPTH  = 8,
    parameter int PID_W  = 6,
    parameter int PRI_W  = 3,
    parameter int TIME_W = 32,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    // field write port
    input  logic              fw_en,
    input  logic [PTR_W-1:0]  fw_addr,
    input  logic [PID_W-1:0]  fw_pid,
    input  logic [PRI_W-1:0]  fw_pri,
    input  logic [TIME_W-1:0] fw_time,
    // link write port
    input  logic              nw_en,
    input  logic [PTR_W-1:0]  nw_addr,
    input  logic [PTR_W-1:0]  nw_data,
    // read port L: all fields
    input  logic [PTR_W-1:0]  l_addr,
    output logic [PID_W-1:0]  l_pid,
    output logic [PRI_W-1:0]  l_pri,
    output logic [TIME_W-1:0] l_time,
    output logic [PTR_W-1:0]  l_next,
    // read port C: time and link
    input  logic [PTR_W-1:0]  c_addr,
    output logic [TIME_W-1:0] c_time,
    output logic [PTR_W-1:0]  c_next,
    // read port F: link only
    input  logic [PTR_W-1:0]  f_addr,
    output logic [PTR_W-1:0]  f_next
);

    logic [PID_W-1:0]  pid_q  [DEPTH];
    logic [PRI_W-1:0]  pri_q  [DEPTH];
    logic [TIME_W-1:0] time_q [DEPTH];
    logic [PTR_W-1:0]  next_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pid_q[gi]  <= '0;
                pri_q[gi]  <= '0;
                time_q[gi] <= '0;
            end else if (fw_en && fw_addr == PTR_W'(gi)) begin
                pid_q[gi]  <= fw_pid;
                pri_q[gi]  <= fw_pri;
                time_q[gi] <= fw_time;
            end
        end

        // at reset every slot is chained to its successor; the last one
        // points at DEPTH, which is the null pointer
        always_ff @(posedge clk) begin
            if (!rst_n)
                next_q[gi] <= PTR_W'(gi + 1);
            else if (nw_en && nw_addr == PTR_W'(gi))
                next_q[gi] <= nw_data;
        end
    end

    always_comb begin
        l_pid  = '0;
        l_pri  = '0;
        l_time = '0;
        l_next = PTR_W'(DEPTH);
        if (l_addr < PTR_W'(DEPTH)) begin
            l_pid  = pid_q[l_addr[IDX_W-1:0]];
            l_pri  = pri_q[l_addr[IDX_W-1:0]];
            l_time = time_q[l_addr[IDX_W-1:0]];
            l_next = next_q[l_addr[IDX_W-1:0]];
        end
    end

    always_comb begin
        c_time = '0;
        c_next = PTR_W'(DEPTH);
        if (c_addr < PTR_W'(DEPTH)) begin
            c_time = time_q[c_addr[IDX_W-1:0]];
            c_next = next_q[c_addr[IDX_W-1:0]];
        end
    end

    always_comb begin
        f_next = PTR_W'(DEPTH);
        if (f_addr < PTR_W'(DEPTH))
            f_next = next_q[f_addr[IDX_W-1:0]];
    end

endmodule

// File: rtl/timed_wake_list.sv
module timed_wake_list
    import wtl_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PID_W  = 6,
    parameter int PRI_W  = 3,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [PID_W-1:0]  ins_pid,
    input  logic [PRI_W-1:0]  ins_pri,
    input  logic [TIME_W-1:0] ins_time,
    output logic              full,
    output logic              wake_valid,
    output logic [PID_W-1:0]  wake_pid,
    output logic [PRI_W-1:0]  wake_pri,
    output logic [TIME_W-1:0] now
);

    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] NIL = PTR_W'(DEPTH);

    wtl_state_e state, state_nx;

    // head registers
    logic              head_valid;
    logic [PID_W-1:0]  head_pid;
    logic [PRI_W-1:0]  head_pri;
    logic [TIME_W-1:0] head_time;

    // list bookkeeping
    logic [PTR_W-1:0]  lst_ptr, free_ptr;
    logic [PTR_W-1:0]  pend_node, prev_ptr, cur_ptr;
    logic [TIME_W-1:0] pend_time;

    // storage interface
    logic              fw_en, nw_en;
    logic [PTR_W-1:0]  fw_addr, nw_addr, nw_data;
    logic [PID_W-1:0]  fw_pid;
    logic [PRI_W-1:0]  fw_pri;
    logic [TIME_W-1:0] fw_time;
    logic [PID_W-1:0]  l_pid;
    logic [PRI_W-1:0]  l_pri;
    logic [TIME_W-1:0] l_time, c_time;
    logic [PTR_W-1:0]  l_next, c_next, f_next;

    logic list_empty, free_empty, expired, is_idle;
    logic do_fire, do_ins, ins_front, walk_stop;
    logic [TIME_W-1:0] list_first_time;

    wtl_rtc #(.TIME_W(TIME_W)) u_rtc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (now)
    );

    wtl_node_ram #(
        .DEPTH (DEPTH),
        .PID_W (PID_W),
        .PRI_W (PRI_W),
        .TIME_W(TIME_W)
    ) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .fw_en  (fw_en),
        .fw_addr(fw_addr),
        .fw_pid (fw_pid),
        .fw_pri (fw_pri),
        .fw_time(fw_time),
        .nw_en  (nw_en),
        .nw_addr(nw_addr),
        .nw_data(nw_data),
        .l_addr (lst_ptr),
        .l_pid  (l_pid),
        .l_pri  (l_pri),
        .l_time (l_time),
        .l_next (l_next),
        .c_addr (cur_ptr),
        .c_time (c_time),
        .c_next (c_next),
        .f_addr (free_ptr),
        .f_next (f_next)
    );

    assign list_first_time = l_time;
    assign list_empty = (lst_ptr == NIL);
    assign free_empty = (free_ptr == NIL);
    assign full       = head_valid && free_empty;
    assign expired    = head_valid && (now > head_time);
    assign is_idle    = (state == S_IDLE);
    assign do_fire    = is_idle && expired;
    assign ins_ready  = is_idle && !expired && !full;
    assign do_ins     = ins_valid && ins_ready;
    assign ins_front  = head_valid && (ins_time < head_time);
    // stop at the first node strictly later, so equal times queue behind
    assign walk_stop  = (cur_ptr == NIL) || (c_time > pend_time);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (do_ins && head_valid && !ins_front) state_nx = S_WALK;
            S_WALK: if (walk_stop) state_nx = S_LINK;
            S_LINK: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // storage write controls
    always_comb begin
        fw_en   = 1'b0;
        fw_addr = free_ptr;
        fw_pid  = ins_pid;
        fw_pri  = ins_pri;
        fw_time = ins_time;
        nw_en   = 1'b0;
        nw_addr = NIL;
        nw_data = NIL;
        unique case (state)
            S_IDLE: begin
                if (do_fire) begin
                    if (!list_empty) begin
                        nw_en   = 1'b1;
                        nw_addr = lst_ptr;
                        nw_data = free_ptr;
                    end
                end else if (do_ins && head_valid) begin
                    fw_en = 1'b1;
                    if (ins_front) begin
                        fw_pid  = head_pid;
                        fw_pri  = head_pri;
                        fw_time = head_time;
                        nw_en   = 1'b1;
                        nw_addr = free_ptr;
                        nw_data = lst_ptr;
                    end
                end
            end
            S_WALK: begin
                if (walk_stop) begin
                    nw_en   = 1'b1;
                    nw_addr = pend_node;
                    nw_data = cur_ptr;
                end
            end
            S_LINK: begin
                if (prev_ptr != NIL) begin
                    nw_en   = 1'b1;
                    nw_addr = prev_ptr;
                    nw_data = pend_node;
                end
            end
            default: ;
        endcase
    end

    // head, list and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_valid <= 1'b0;
            head_pid   <= '0;
            head_pri   <= '0;
            head_time  <= '0;
            lst_ptr    <= NIL;
            free_ptr   <= '0;
            pend_node  <= NIL;
            prev_ptr   <= NIL;
            cur_ptr    <= NIL;
            pend_time  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (do_fire) begin
                        if (list_empty) begin
                            head_valid <= 1'b0;
                        end else begin
                            head_pid  <= l_pid;
                            head_pri  <= l_pri;
                            head_time <= l_time;
                            lst_ptr   <= l_next;
                            free_ptr  <= lst_ptr;
                        end
                    end else if (do_ins) begin
                        if (!head_valid || ins_front) begin
                            head_valid <= 1'b1;
                            head_pid   <= ins_pid;
                            head_pri   <= ins_pri;
                            head_time  <= ins_time;
                            if (ins_front) begin
                                lst_ptr  <= free_ptr;
                                free_ptr <= f_next;
                            end
                        end else begin
                            pend_node <= free_ptr;
                            pend_time <= ins_time;
                            free_ptr  <= f_next;
                            prev_ptr  <= NIL;
                            cur_ptr   <= lst_ptr;
                        end
                    end
                end
                S_WALK: begin
                    if (!walk_stop) begin
                        prev_ptr <= cur_ptr;
                        cur_ptr  <= c_next;
                    end
                end
                S_LINK: begin
                    if (prev_ptr == NIL) lst_ptr <= pend_node;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_valid <= 1'b0;
            wake_pid   <= '0;
            wake_pri   <= '0;
        end else begin
            wake_valid <= do_fire;
            if (do_fire) begin
                wake_pid <= head_pid;
                wake_pri <= head_pri;
            end
        end
    end

endmodule

// File: rtl/timed_wake_list_chk.sv
module timed_wake_list_chk #(
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_ready,
    input logic              full,
    input logic              wake_valid,
    input logic [TIME_W-1:0] now,
    input logic              head_valid,
    input logic [TIME_W-1:0] head_time,
    input logic              list_empty,
    input logic [TIME_W-1:0] list_first_time
);

    // R1: counter steps by one each cycle
    p_now_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (now - $past(now)) == TIME_W'(1));

    // R1: an empty queue stays silent
    p_empty_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |=> !wake_valid);

    // R3: a wakeup follows a cycle where the counter had passed the head time
    p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> ($past(head_valid) && ($past(now) > $past(head_time))));

    // R4: the head never lies later than the first list node
    p_sorted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !list_empty) |-> (head_time <= list_first_time));

    // R8: no accept while full
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !ins_ready);

endmodule

bind timed_wake_list timed_wake_list_chk #(.TIME_W(TIME_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ins_ready      (ins_ready),
    .full           (full),
    .wake_valid     (wake_valid),
    .now            (now),
    .head_valid     (head_valid),
    .head_time      (head_time),
    .list_empty     (list_empty),
    .list_first_time(list_first_time)
);

// File: tb/timed_wake_list_tb.sv
module timed_wake_list_tb;

    localparam int DEPTH  = 4;
    localparam int PID_W  = 8;
    localparam int PRI_W  = 4;
    localparam int TIME_W = 16;
    localparam int GRP    = DEPTH + 1;

    typedef struct packed {
        logic [7:0]  pid;
        logic [3:0]  pri;
        logic [15:0] off;
    } vec_t;

    // two groups of GRP requests; offsets are added to a base time
    localparam vec_t VEC [2*GRP] = '{
        '{8'd11, 4'd1, 16'd200}, '{8'd12, 4'd2, 16'd100}, '{8'd13, 4'd3, 16'd300},
        '{8'd14, 4'd4, 16'd100}, '{8'd15, 4'd5, 16'd50},
        '{8'd21, 4'd6, 16'd40},  '{8'd22, 4'd7, 16'd40},  '{8'd23, 4'd8, 16'd40},
        '{8'd24, 4'd9, 16'd10},  '{8'd25, 4'd10, 16'd90}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic              ins_ready;
    logic [PID_W-1:0]  ins_pid = '0;
    logic [PRI_W-1:0]  ins_pri = '0;
    logic [TIME_W-1:0] ins_time = '0;
    logic              full;
    logic              wake_valid;
    logic [PID_W-1:0]  wake_pid;
    logic [PRI_W-1:0]  wake_pri;
    logic [TIME_W-1:0] now;

    int n_checks = 0;
    int n_fail   = 0;
    int wn       = 0;
    int w_pid [32];
    int w_pri [32];
    int w_now [32];
    int cyc      = 0;

    always #2.5 clk = ~clk;

    timed_wake_list #(
        .DEPTH (DEPTH),
        .PID_W (PID_W),
        .PRI_W (PRI_W),
        .TIME_W(TIME_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .ins_ready (ins_ready),
        .ins_pid   (ins_pid),
        .ins_pri   (ins_pri),
        .ins_time  (ins_time),
        .full      (full),
        .wake_valid(wake_valid),
        .wake_pid  (wake_pid),
        .wake_pri  (wake_pri),
        .now       (now)
    );

    always @(negedge clk) begin
        if (rst_n && wake_valid && wn < 32) begin
            w_pid[wn] = int'(wake_pid);
            w_pri[wn] = int'(wake_pri);
            w_now[wn] = int'(now);
            wn = wn + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic put(input int pid, input int pri, input int t);
        int guard = 0;
        @(negedge clk);
        ins_valid = 1'b1;
        ins_pid   = PID_W'(pid);
        ins_pri   = PRI_W'(pri);
        ins_time  = TIME_W'(t);
        while (!ins_ready && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic wait_wakes(input int n);
        int guard = 0;
        while (wn < n && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // applies one group, then checks order, timing and payload
    task automatic run_group(input int g);
        int  base, first, prev_now, pick, exp_now;
        int  tm [GRP];
        bit  used [GRP];
        @(negedge clk);
        base  = int'(now) + 40;
        first = wn;
        for (int i = 0; i < GRP; i++) begin
            tm[i]   = base + int'(VEC[g*GRP+i].off);
            used[i] = 1'b0;
            put(int'(VEC[g*GRP+i].pid), int'(VEC[g*GRP+i].pri), tm[i]);
        end
        // R8: storage exhausted, extra request held off
        chk(full == 1'b1, "R8 full after fill", int'(full), 1);
        @(negedge clk);
        ins_valid = 1'b1;
        ins_pid   = 8'd99;
        ins_pri   = 4'd15;
        ins_time  = TIME_W'(base);
        for (int k = 0; k < 3; k++) begin
            chk(ins_ready == 1'b0, "R8 ready low while full", int'(ins_ready), 0);
            @(negedge clk);
        end
        ins_valid = 1'b0;
        wait_wakes(first + GRP);
        chk(wn == first + GRP, "R7 wake count", wn - first, GRP);
        prev_now = 0;
        for (int k = 0; k < GRP; k++) begin
            pick = -1;
            for (int i = 0; i < GRP; i++)
                if (!used[i] && (pick < 0 || tm[i] < tm[pick])) pick = i;
            used[pick] = 1'b1;
            exp_now = (tm[pick] + 2 > prev_now + 1) ? tm[pick] + 2 : prev_now + 1;
            // R4 R5 R6: order by time, ties in acceptance order
            chk(w_pid[first+k] == int'(VEC[g*GRP+pick].pid), "R4 R5 R6 order pid",
                w_pid[first+k], int'(VEC[g*GRP+pick].pid));
            // R10: priority carried through
            chk(w_pri[first+k] == int'(VEC[g*GRP+pick].pri), "R10 priority",
                w_pri[first+k], int'(VEC[g*GRP+pick].pri));
            // R2 R3 R7: exact wake cycle
            chk(w_now[first+k] == exp_now, "R2 R3 R7 wake cycle", w_now[first+k], exp_now);
            prev_now = w_now[first+k];
        end
        @(negedge clk);
        // R9: slots came back
        chk(full == 1'b0, "R9 full cleared after drain", int'(full), 0);
        chk(ins_ready == 1'b1, "R9 ready after drain", int'(ins_ready), 1);
    endtask

    initial begin
        int a, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(wake_valid == 1'b0, "R1 wake_valid after reset", int'(wake_valid), 0);
        chk(full == 1'b0, "R1 full after reset", int'(full), 0);
        chk(ins_ready == 1'b1, "R1 ready after reset", int'(ins_ready), 1);
        chk(now == TIME_W'(1), "R1 counter after first edge", int'(now), 1);
        a = int'(now);
        @(negedge clk);
        chk(int'(now) == a + 1, "R1 counter step", int'(now), a + 1);

        // R2 R3 R10: isolated request
        t = int'(now) + 20;
        put(9, 3, t);
        wait_wakes(1);
        chk(wn == 1, "R3 single wake", wn, 1);
        chk(w_now[0] == t + 2, "R2 isolated wake cycle", w_now[0], t + 2);
        chk(w_pid[0] == 9, "R10 isolated pid", w_pid[0], 9);
        chk(w_pri[0] == 3, "R10 isolated pri", w_pri[0], 3);

        // table-driven groups
        for (int g = 0; g < 2; g++) run_group(g);

        // R3: nothing further emitted; the refused request never entered
        repeat (20) @(negedge clk);
        chk(wn == 1 + 2*GRP, "R3 R8 no stray wake", wn, 1 + 2*GRP);
        finish_run();
    end

endmodule